// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Prescaler

This block takes an undivided source clock and produces a system clock at the source rate divided by 1, 2, 4 and so on up to 256. A four-bit select value picks the division factor. A write strobe that is sampled on the rising source edge captures the select value. The divided clock has a 50% duty cycle for every factor of two or more. At a factor of one it follows the source clock.

Software can change the factor while the clock runs. The new value is held as pending. It takes effect only when the current output period has finished, and the division counter then starts again from zero. Output edges come only from registered state or from a gate that switches while the source is low. This means no output high or low phase is ever shorter than the matching phase of the old setting or the new setting. A second output can drive a pin with the divided clock. It is gated on a quiet phase, and it stays low while reset is asserted.

Top module: `clk_prescaler`

## Requirements
- R1: After reset is released the division factor is 8. The output period is 8 source cycles, with 4 cycles high then 4 cycles low, until a different valid select value is written.
- R2: Select value k, for k in 0..8, sets the division factor to 2^k. In steady state each output period is 2^k source cycles. For k >= 1 the output is high for 2^(k-1) cycles and low for 2^(k-1) cycles. For k = 0 the output equals the source clock.
- R3: A write whose select value is 9..15 is ignored. The active factor and any value already pending stay unchanged.
- R4: A valid write is applied only at the end of the output period that is running when it is sampled. That period keeps its old length, and the counter restarts from zero under the new factor.
- R5: While switching, no output high or low phase is shorter than half the source-cycle period of the smaller of the old and new factors. No output period is shorter than that smaller period.
- R6: The new output period is in effect no later than T1 + 2*T2 + 2 source cycles after the write strobe, where T1 is the old period and T2 is the new period.
- R7: When the pin enable is high, the clock-out pin follows the divided clock. When it is low, the pin stays low. The enable changes only while the divided clock is in its low phase.
- R8: While the asynchronous active-low reset is asserted, the clock-out pin and the divided clock are both low.
- R9: If several valid writes are sampled inside one output period, the last one is the one applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Undivided source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| sel_we | input | 1 | Select write strobe, sampled on the rising source edge |
| sel_val | input | 4 | Select value, where k gives a division factor of 2^k |
| cko_en | input | 1 | Clock-out pin enable |
| div_clk | output | 1 | Divided system clock |
| cko_pin | output | 1 | Gated copy of the divided clock for the pin |

## Verification
On every source cycle the assertions check four things. The active setting stays in range and changes only on a period boundary, where the counter restarts. Out-of-range writes leave the pending value alone, and the last valid write is the one captured. The high phase always ends at the counter midpoint, and the pin stays low during reset. Other properties depend on real edge timing, so only the bench scenarios can show them. These are the absence of short phases across a switch, the bound on switching latency, the exact steady-state period and duty at each factor, and the pin following the divided clock. The bench measures these from output edge times, using random and directed setting changes.

// File: rtl/cdv_pkg.sv
`timescale 1ns/1ps
package cdv_pkg;
  localparam int unsigned DEF_MAX_LOG   = 8;
  localparam int unsigned DEF_SEL_W     = 4;
  localparam int unsigned DEF_RESET_LOG = 3;
  localparam int unsigned DEF_SYNC_DEPTH = 2;

  function automatic int unsigned log_width(input int unsigned max_log);
    return $clog2(max_log + 1);
  endfunction
endpackage

// File: rtl/cdv_reset_sync.sv
`timescale 1ns/1ps
module cdv_reset_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_n;

  always_comb begin
    stage_n = {stage_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_n;
  end

  assign srst_n = stage_q[DEPTH-1];
endmodule

// File: rtl/cdv_select_reg.sv
`timescale 1ns/1ps
module cdv_select_reg #(
  parameter int unsigned MAX_LOG   = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned RESET_LOG = 3,
  parameter int unsigned LOG_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] val,
  input  logic             apply,
  output logic [LOG_W-1:0] act_log,
  output logic [LOG_W-1:0] nxt_log,
  output logic [LOG_W-1:0] pend_log,
  output logic             pend_vld
);
  localparam logic [LOG_W-1:0] RST_LOG = LOG_W'(RESET_LOG);

  logic             val_ok;
  logic             take;
  logic [LOG_W-1:0] act_q, act_n;
  logic [LOG_W-1:0] pend_q, pend_n;
  logic             vld_q, vld_n;

  always_comb begin
    val_ok = (32'(val) <= 32'(MAX_LOG));
    take   = we && val_ok;
    // the active setting moves only on a period boundary
    act_n  = act_q;
    if (apply && vld_q) act_n = pend_q;
    pend_n = pend_q;
    vld_n  = vld_q;
    if (apply) vld_n = 1'b0;
    if (take) begin
      pend_n = LOG_W'(val);
      vld_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= RST_LOG;
      pend_q <= RST_LOG;
      vld_q  <= 1'b0;
    end else begin
      act_q  <= act_n;
      pend_q <= pend_n;
      vld_q  <= vld_n;
    end
  end

  assign act_log  = act_q;
  assign nxt_log  = vld_q ? pend_q : act_q;
  assign pend_log = pend_q;
  assign pend_vld = vld_q;
endmodule

// File: rtl/cdv_div_core.sv
`timescale 1ns/1ps
module cdv_div_core #(
  parameter int unsigned MAX_LOG   = 8,
  parameter int unsigned RESET_LOG = 3,
  parameter int unsigned LOG_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOG_W-1:0]   act_log,
  input  logic [LOG_W-1:0]   nxt_log,
  output logic               wrap,
  output logic [MAX_LOG:0]   cnt,
  output logic               phase
);
  localparam int unsigned CNT_W = MAX_LOG + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_CNT = (ONE << RESET_LOG) - ONE;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_n;
  logic             phase_q, phase_n;
  logic [LOG_W-1:0] log_sel;

  always_comb begin
    last_cnt = (ONE << act_log) - ONE;
    wrap     = (cnt_q == last_cnt);
    cnt_n    = wrap ? '0 : cnt_q + ONE;
    log_sel  = wrap ? nxt_log : act_log;
    half_n   = (ONE << log_sel) >> 1;
    phase_n  = (cnt_n < half_n);
  end

  // reset leaves the counter on its last count so the first period starts at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RST_CNT;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      phase_q <= phase_n;
    end
  end

  assign cnt   = cnt_q;
  assign phase = phase_q;
endmodule

// File: rtl/cdv_clk_out.sv
`timescale 1ns/1ps
module cdv_clk_out (
  input  logic src_clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic phase,
  input  logic cko_en,
  output logic div_clk,
  output logic cko_pin
);
  logic byp_q, byp_n;
  logic pin_q, pin_n;

  always_comb begin
    byp_n = bypass;
    // the pin enable moves only while the divided clock is low
    pin_n = phase ? pin_q : cko_en;
  end

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      byp_q <= byp_n;
      pin_q <= pin_n;
    end
  end

  assign div_clk = phase | (byp_q & src_clk);
  assign cko_pin = div_clk & pin_q;
endmodule

// File: rtl/clk_prescaler.sv
`timescale 1ns/1ps
module clk_prescaler #(
  parameter int unsigned MAX_LOG    = cdv_pkg::DEF_MAX_LOG,
  parameter int unsigned SEL_W      = cdv_pkg::DEF_SEL_W,
  parameter int unsigned RESET_LOG  = cdv_pkg::DEF_RESET_LOG,
  parameter int unsigned SYNC_DEPTH = cdv_pkg::DEF_SYNC_DEPTH
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_val,
  input  logic             cko_en,
  output logic             div_clk,
  output logic             cko_pin
);
  localparam int unsigned LOG_W = cdv_pkg::log_width(MAX_LOG);

  logic             rst_sync_n;
  logic [LOG_W-1:0] act_log;
  logic [LOG_W-1:0] nxt_log;
  logic [LOG_W-1:0] pend_log;
  logic             pend_vld;
  logic             wrap;
  logic [MAX_LOG:0] cnt;
  logic             phase;
  logic             bypass;

  cdv_reset_sync #(.DEPTH(SYNC_DEPTH)) u_rst (
    .clk    (src_clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  cdv_select_reg #(
    .MAX_LOG(MAX_LOG), .SEL_W(SEL_W), .RESET_LOG(RESET_LOG), .LOG_W(LOG_W)
  ) u_sel (
    .clk      (src_clk),
    .rst_n    (rst_sync_n),
    .we       (sel_we),
    .val      (sel_val),
    .apply    (wrap),
    .act_log  (act_log),
    .nxt_log  (nxt_log),
    .pend_log (pend_log),
    .pend_vld (pend_vld)
  );

  cdv_div_core #(
    .MAX_LOG(MAX_LOG), .RESET_LOG(RESET_LOG), .LOG_W(LOG_W)
  ) u_core (
    .clk     (src_clk),
    .rst_n   (rst_sync_n),
    .act_log (act_log),
    .nxt_log (nxt_log),
    .wrap    (wrap),
    .cnt     (cnt),
    .phase   (phase)
  );

  assign bypass = (act_log == '0);

  cdv_clk_out u_out (
    .src_clk (src_clk),
    .rst_n   (rst_sync_n),
    .bypass  (bypass),
    .phase   (phase),
    .cko_en  (cko_en),
    .div_clk (div_clk),
    .cko_pin (cko_pin)
  );
endmodule

// File: rtl/cdv_checker.sv
`timescale 1ns/1ps
module cdv_checker #(
  parameter int unsigned MAX_LOG = 8,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned LOG_W   = 4
) (
  input logic             src_clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             sel_we,
  input logic [SEL_W-1:0] sel_val,
  input logic [LOG_W-1:0] act_log,
  input logic [LOG_W-1:0] pend_log,
  input logic             pend_vld,
  input logic             wrap,
  input logic [MAX_LOG:0] cnt,
  input logic             phase,
  input logic             cko_pin
);
  logic             bad_sel;
  logic             good_sel;
  logic [MAX_LOG:0] mid_cnt;

  always_comb begin
    bad_sel  = sel_we && (32'(sel_val) > 32'(MAX_LOG));
    good_sel = sel_we && (32'(sel_val) <= 32'(MAX_LOG));
    mid_cnt  = ((MAX_LOG+1)'(1) << act_log) >> 1;
  end

  assert_setting_range_R2: assert property (@(posedge src_clk) disable iff (!rst_sync_n)
    32'(act_log) <= 32'(MAX_LOG));

  assert_apply_on_boundary_R4: assert property (@(posedge src_clk) disable iff (!rst_sync_n)
    (act_log != $past(act_log)) |-> $past(wrap));

  assert_counter_restart_R4: assert property (@(posedge src_clk) disable iff (!rst_sync_n)
    wrap |=> (cnt == '0));

  assert_bad_select_ignored_R3: assert property (@(posedge src_clk) disable iff (!rst_sync_n)
    bad_sel |=> (pend_log == $past(pend_log)));

  assert_last_write_kept_R9: assert property (@(posedge src_clk) disable iff (!rst_sync_n)
    good_sel |=> (pend_vld && (32'(pend_log) == 32'($past(sel_val)))));

  assert_high_ends_mid_R5: assert property (@(posedge src_clk) disable iff (!rst_sync_n)
    $fell(phase) |-> (cnt == mid_cnt));

  assert_pin_low_in_reset_R8: assert property (@(posedge src_clk)
    !rst_n |-> !cko_pin);
endmodule

bind clk_prescaler cdv_checker #(
  .MAX_LOG(MAX_LOG), .SEL_W(SEL_W), .LOG_W(LOG_W)
) u_chk (
  .src_clk    (src_clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .sel_we     (sel_we),
  .sel_val    (sel_val),
  .act_log    (act_log),
  .pend_log   (pend_log),
  .pend_vld   (pend_vld),
  .wrap       (wrap),
  .cnt        (cnt),
  .phase      (phase),
  .cko_pin    (cko_pin)
);

// File: tb/clk_prescaler_tb.sv
`timescale 1ns/1ps
module clk_prescaler_tb;
  localparam real TCLK = 5.0;
  localparam real TOL  = 0.01;

  logic       src_clk;
  logic       rst_n;
  logic       sel_we;
  logic [3:0] sel_val;
  logic       cko_en;
  logic       div_clk;
  logic       cko_pin;

  int  n_checks;
  int  n_fail;
  bit  done;
  bit  mon_en;
  bit  have_edge;
  real last_t;
  real floor_ns;
  int  cur;

  clk_prescaler u_dut (
    .src_clk (src_clk),
    .rst_n   (rst_n),
    .sel_we  (sel_we),
    .sel_val (sel_val),
    .cko_en  (cko_en),
    .div_clk (div_clk),
    .cko_pin (cko_pin)
  );

  initial src_clk = 1'b0;
  always #2.5 src_clk = ~src_clk;

  function automatic real per_ns(input int lg);
    return real'(1 << lg) * TCLK;
  endfunction

  function automatic real minr(input real a, input real b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0.3f expected=%0.3f at %0t", req, act, exp, $time);
    end
  endtask

  // R5: every output phase against the current floor
  always @(div_clk) begin
    if (mon_en) begin
      if (have_edge)
        chk(($realtime - last_t) >= floor_ns - TOL, "R5 phase width",
            $realtime - last_t, floor_ns);
      have_edge = 1'b1;
      last_t = $realtime;
    end else begin
      have_edge = 1'b0;
    end
  end

  task automatic write_sel(input int v);
    @(negedge src_clk);
    sel_we  = 1'b1;
    sel_val = 4'(v);
    @(negedge src_clk);
    sel_we  = 1'b0;
  endtask

  task automatic meas_period(output real p);
    real t0;
    @(posedge div_clk); t0 = $realtime;
    @(posedge div_clk); p = $realtime - t0;
  endtask

  task automatic meas_high(output real h);
    real t0;
    @(posedge div_clk); t0 = $realtime;
    @(negedge div_clk); h = $realtime - t0;
  endtask

  task automatic check_steady(input int lg, input string req);
    real p;
    real h;
    meas_period(p);
    chk((p > per_ns(lg) - TOL) && (p < per_ns(lg) + TOL), req, p, per_ns(lg));
    meas_high(h);
    chk((h > per_ns(lg) / 2.0 - TOL) && (h < per_ns(lg) / 2.0 + TOL), req, h, per_ns(lg) / 2.0);
  endtask

  // valid change with latency and switch-floor handling (R5, R6)
  task automatic change_to(input int nv);
    int wait_cyc;
    real p;
    floor_ns = minr(per_ns(cur), per_ns(nv)) / 2.0;
    wait_cyc = (1 << cur) + 2 * (1 << nv) + 2;
    write_sel(nv);
    repeat (wait_cyc) @(posedge src_clk);
    meas_period(p);
    chk((p > per_ns(nv) - TOL) && (p < per_ns(nv) + TOL), "R6 latency bound", p, per_ns(nv));
    cur = nv;
    floor_ns = per_ns(cur) / 2.0;
  endtask

  task automatic do_reset();
    mon_en = 1'b0;
    @(negedge src_clk);
    rst_n = 1'b0;
    #1;
    chk(cko_pin == 1'b0, "R8 pin low in reset", real'(cko_pin), 0.0);
    chk(div_clk == 1'b0, "R8 clock low in reset", real'(div_clk), 0.0);
    repeat (5) @(posedge src_clk);
    #1;
    chk(cko_pin == 1'b0, "R8 pin held low", real'(cko_pin), 0.0);
    @(negedge src_clk);
    rst_n = 1'b1;
    cur = 3;
    floor_ns = per_ns(3) / 2.0;
    repeat (3) @(posedge src_clk);
    mon_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge src_clk);
    if (!done) begin
      chk(1'b0, "WATCHDOG expired", 0.0, 1.0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    real p;
    real ta;
    real tb;
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    mon_en = 1'b0;
    have_edge = 1'b0;
    last_t = 0.0;
    floor_ns = 0.0;
    cur = 3;
    rst_n = 1'b0;
    sel_we = 1'b0;
    sel_val = 4'd0;
    cko_en = 1'b0;
    void'($urandom(32'd20240611));

    repeat (4) @(posedge src_clk);
    #1;
    chk(div_clk == 1'b0, "R8 reset clock low", real'(div_clk), 0.0);
    chk(cko_pin == 1'b0, "R8 reset pin low", real'(cko_pin), 0.0);
    @(negedge src_clk);
    rst_n = 1'b1;
    floor_ns = per_ns(3) / 2.0;
    repeat (3) @(posedge src_clk);
    mon_en = 1'b1;

    // R1: default divide by 8 with even duty
    check_steady(3, "R1 default divide");

    // R2: every factor, each reached from its neighbour
    for (int k = 0; k <= 8; k++) begin
      change_to(k);
      check_steady(k, "R2 steady factor");
    end
    change_to(0);
    check_steady(0, "R2 factor one");

    // R3: out-of-range writes ignored
    change_to(2);
    write_sel(9);
    write_sel(15);
    repeat (20) @(posedge src_clk);
    check_steady(2, "R3 bad select ignored");

    // R3: a bad write after a pending good one leaves the good one
    change_to(3);
    @(posedge div_clk);
    write_sel(1);
    write_sel(12);
    floor_ns = per_ns(1) / 2.0;
    repeat (30) @(posedge src_clk);
    check_steady(1, "R3 pending kept");
    cur = 1;

    // R4: current period completes before the new factor applies
    change_to(3);
    @(posedge div_clk); ta = $realtime;
    floor_ns = per_ns(1) / 2.0;
    write_sel(1);
    @(posedge div_clk); tb = $realtime;
    chk((tb - ta > per_ns(3) - TOL) && (tb - ta < per_ns(3) + TOL), "R4 old period kept",
        tb - ta, per_ns(3));
    meas_period(p);
    chk((p > per_ns(1) - TOL) && (p < per_ns(1) + TOL), "R4 restart under new factor",
        p, per_ns(1));
    cur = 1;

    // R9: last of several writes in one period wins
    change_to(4);
    @(posedge div_clk);
    floor_ns = per_ns(2) / 2.0;
    write_sel(6);
    write_sel(2);
    repeat (40) @(posedge src_clk);
    check_steady(2, "R9 last write wins");
    cur = 2;

    // R7: pin enable
    cko_en = 1'b1;
    repeat (2) @(posedge div_clk);
    for (int i = 0; i < 12; i++) begin
      @(posedge src_clk); #1;
      chk(cko_pin == div_clk, "R7 pin follows clock", real'(cko_pin), real'(div_clk));
    end
    change_to(0);
    for (int i = 0; i < 6; i++) begin
      @(posedge src_clk); #1;
      chk(cko_pin == div_clk, "R7 pin follows fast clock", real'(cko_pin), real'(div_clk));
    end
    cko_en = 1'b0;
    repeat (4) @(posedge src_clk);
    for (int i = 0; i < 8; i++) begin
      @(posedge src_clk); #1;
      chk(cko_pin == 1'b0, "R7 pin disabled", real'(cko_pin), 0.0);
    end

    // R8: reset mid-run with the pin enabled, then R1 again
    change_to(5);
    cko_en = 1'b1;
    repeat (3) @(posedge div_clk);
    do_reset();
    check_steady(3, "R1 after second reset");

    // random walk of settings, with bad values mixed in
    for (int it = 0; it < 40; it++) begin
      int v;
      v = int'($urandom_range(0, 11));
      repeat (int'($urandom_range(0, 7))) @(negedge src_clk);
      if (v <= 8) begin
        change_to(v);
      end else begin
        write_sel(v);
        repeat (4) @(posedge src_clk);
        meas_period(p);
        chk((p > per_ns(cur) - TOL) && (p < per_ns(cur) + TOL), "R3 random bad select",
            p, per_ns(cur));
      end
    end
    check_steady(cur, "R2 final steady");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule